// File: doc/BRIEF.md
# Per-Core SMI Pending and Wake Controller

Each core has one of these controllers. It decides the cycle in which a system-management interrupt request turns into an entry into system-management mode. The controller tracks whether the core is running, halted, inside SMM, or parked after reset or INIT until a startup IPI arrives. Incoming SMI requests go into one sticky pending bit. That bit is serviced only where the core's current state allows it.

A parked core never enters SMM directly. It holds the request until a startup IPI arrives. It then signals that the initial state must be loaded from the IPI vector, and in the very next cycle it requests SMM entry, before any instruction at that vector runs. The captured vector is kept on an output so that, after SMM exits, execution resumes at the first instruction the startup IPI named. The `IS_BSP` parameter marks the bootstrap core. That core leaves reset running and is never parked.

The state after each clock edge is one of these: parked, boot (one cycle after the IPI load), running, halted, or in SMM. Every output is registered and appears in the cycle after the edge that decided it.

Top module: `smi_wake_ctl`

## Requirements
- R1: After reset, all outputs are 0 and nothing is pending. A non-bootstrap core starts parked, waiting for a startup IPI. A bootstrap core starts running.
- R2: A running core with a pending SMI pulses `smm_enter_o` one cycle after an edge where `insn_bnd_i` is 1. While it runs, an edge without `insn_bnd_i` never causes an entry.
- R3: A halted core with a pending SMI needs no boundary strobe. `halt_exit_o` and `smm_enter_o` pulse together, one cycle after the first edge where the pending bit is set while halted.
- R4: A parked core never asserts `smm_enter_o`. An SMI that arrives while parked stays pending.
- R5: A startup IPI received while parked pulses `load_init_o` one cycle later, with `resume_vec_o` equal to `sipi_vec_i`. If an SMI is pending, `smm_enter_o` pulses in the cycle after that. Otherwise the core runs.
- R6: Any number of SMI pulses that arrive before service merge into a single SMM entry.
- R7: `init_i` parks a non-bootstrap core but keeps an SMI that is already pending. `init_i` takes priority over every other event in the same cycle.
- R8: A startup IPI that arrives when the core is not parked has no effect. `load_init_o` stays 0 and `resume_vec_o` does not change.
- R9: SMI requests that arrive while in SMM are latched. After `smm_exit_i` they are taken at the next instruction boundary.
- R10: `smm_enter_o` is high for exactly one cycle. The pending bit clears at the same edge, unless a new request arrives at that edge.
- R11: A bootstrap core is never parked. After `init_i` it stays running and takes a pending SMI at the next boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smi_req_i | input | 1 | SMI request pulse |
| init_i | input | 1 | Reset/INIT event for the core |
| sipi_i | input | 1 | Startup IPI event |
| sipi_vec_i | input | VEC_W | Startup IPI vector |
| insn_bnd_i | input | 1 | Instruction boundary strobe |
| halt_enter_i | input | 1 | Core enters the halt state |
| smm_exit_i | input | 1 | Core leaves SMM (resume) |
| smm_enter_o | output | 1 | SMM entry request, one-cycle pulse |
| halt_exit_o | output | 1 | Halt left because of an SMI |
| load_init_o | output | 1 | Load initial state from the startup vector |
| resume_vec_o | output | VEC_W | Captured startup vector |

## Verification
The assertions check these rules on every cycle:
- the entry pulse lasts one cycle;
- a parked core never enters SMM, and a running core never enters without a boundary;
- a halt exit always comes with an entry;
- a request always sets the pending bit;
- a startup IPI outside the parked state leaves the vector alone.

Some behaviour only the bench's scenarios can show. These are the ordering of the initial-state load ahead of a deferred entry, the merging of several requests into exactly one entry, a pending request surviving INIT, and a request latched inside SMM being taken after the exit. The bench shows these by running a reference model alongside the design and by checking directed sequences, on both a bootstrap and a non-bootstrap instance.

// File: rtl/smi_wake_pkg.sv
package smi_wake_pkg;
  typedef enum logic [2:0] {
    ST_PARK = 3'd0,
    ST_BOOT = 3'd1,
    ST_RUN  = 3'd2,
    ST_HALT = 3'd3,
    ST_SMM  = 3'd4
  } core_st_e;
endpackage

// File: rtl/smi_pend_flag.sv
module smi_pend_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic pend_o
);
  logic pend_q;

  // a request at the service edge survives the clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else         pend_q <= set_i | (pend_q & ~clr_i);
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/smi_run_fsm.sv
module smi_run_fsm
  import smi_wake_pkg::*;
#(
  parameter bit IS_BSP = 1'b0
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     init_i,
  input  logic     sipi_i,
  input  logic     bnd_i,
  input  logic     halt_i,
  input  logic     exit_i,
  input  logic     pend_i,
  output logic     take_o,
  output logic     hexit_o,
  output logic     load_o,
  output core_st_e state_o
);
  core_st_e state_q, state_d, init_tgt;

  generate
    if (IS_BSP) begin : g_bsp
      assign init_tgt = ST_RUN;
    end else begin : g_ap
      assign init_tgt = ST_PARK;
    end
  endgenerate

  always_comb begin
    state_d = state_q;
    take_o  = 1'b0;
    hexit_o = 1'b0;
    load_o  = 1'b0;
    if (init_i) begin
      state_d = init_tgt;
    end else begin
      unique case (state_q)
        ST_PARK: if (sipi_i) begin
          load_o  = 1'b1;
          state_d = ST_BOOT;
        end
        ST_BOOT: begin
          // deferred SMI goes ahead of the first instruction
          take_o  = pend_i;
          state_d = pend_i ? ST_SMM : ST_RUN;
        end
        ST_RUN: begin
          if (bnd_i && pend_i) begin
            take_o  = 1'b1;
            state_d = ST_SMM;
          end else if (halt_i) begin
            state_d = ST_HALT;
          end
        end
        ST_HALT: if (pend_i) begin
          take_o  = 1'b1;
          hexit_o = 1'b1;
          state_d = ST_SMM;
        end
        ST_SMM: if (exit_i) state_d = ST_RUN;
        default: state_d = init_tgt;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= init_tgt;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/smi_vec_reg.sv
module smi_vec_reg #(
  parameter int VEC_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [VEC_W-1:0] vec_i,
  output logic [VEC_W-1:0] vec_o
);
  logic [VEC_W-1:0] vec_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     vec_q <= '0;
    else if (load_i) vec_q <= vec_i;
  end

  assign vec_o = vec_q;
endmodule

// File: rtl/smi_wake_ctl.sv
module smi_wake_ctl
  import smi_wake_pkg::*;
#(
  parameter bit IS_BSP = 1'b0,
  parameter int VEC_W  = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             smi_req_i,
  input  logic             init_i,
  input  logic             sipi_i,
  input  logic [VEC_W-1:0] sipi_vec_i,
  input  logic             insn_bnd_i,
  input  logic             halt_enter_i,
  input  logic             smm_exit_i,
  output logic             smm_enter_o,
  output logic             halt_exit_o,
  output logic             load_init_o,
  output logic [VEC_W-1:0] resume_vec_o
);
  logic     pend_q, take, hexit, load;
  core_st_e state_q;
  logic     enter_q, hexit_q, load_q;

  smi_pend_flag u_pend (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (smi_req_i),
    .clr_i  (take),
    .pend_o (pend_q)
  );

  smi_run_fsm #(.IS_BSP(IS_BSP)) u_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .init_i  (init_i),
    .sipi_i  (sipi_i),
    .bnd_i   (insn_bnd_i),
    .halt_i  (halt_enter_i),
    .exit_i  (smm_exit_i),
    .pend_i  (pend_q),
    .take_o  (take),
    .hexit_o (hexit),
    .load_o  (load),
    .state_o (state_q)
  );

  smi_vec_reg #(.VEC_W(VEC_W)) u_vec (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .vec_i  (sipi_vec_i),
    .vec_o  (resume_vec_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      enter_q <= 1'b0;
      hexit_q <= 1'b0;
      load_q  <= 1'b0;
    end else begin
      enter_q <= take;
      hexit_q <= hexit;
      load_q  <= load;
    end
  end

  assign smm_enter_o = enter_q;
  assign halt_exit_o = hexit_q;
  assign load_init_o = load_q;
endmodule

// File: rtl/smi_wake_ctl_chk.sv
module smi_wake_ctl_chk
  import smi_wake_pkg::*;
#(
  parameter bit IS_BSP = 1'b0,
  parameter int VEC_W  = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             smi_req_i,
  input logic             init_i,
  input logic             sipi_i,
  input logic [VEC_W-1:0] sipi_vec_i,
  input logic             insn_bnd_i,
  input logic             smm_enter_o,
  input logic             halt_exit_o,
  input logic             load_init_o,
  input logic [VEC_W-1:0] resume_vec_o,
  input logic             pend_q,
  input core_st_e         state_q
);
  p_no_park_entry_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PARK) |=> !smm_enter_o);

  p_run_needs_bnd_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && !insn_bnd_i) |=> !smm_enter_o);

  p_halt_exit_enter_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_exit_o |-> smm_enter_o);

  p_sipi_load_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PARK && sipi_i && !init_i) |=>
      (load_init_o && resume_vec_o == $past(sipi_vec_i)));

  p_sipi_ignored_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_PARK) |=> ($stable(resume_vec_o) && !load_init_o));

  p_req_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smi_req_i |=> pend_q);

  p_enter_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smm_enter_o |=> !smm_enter_o);

  p_pend_cleared_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smm_enter_o |-> (pend_q == $past(smi_req_i)));

  p_bsp_never_parked_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    IS_BSP |-> (state_q != ST_PARK));
endmodule

bind smi_wake_ctl smi_wake_ctl_chk #(.IS_BSP(IS_BSP), .VEC_W(VEC_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .smi_req_i    (smi_req_i),
  .init_i       (init_i),
  .sipi_i       (sipi_i),
  .sipi_vec_i   (sipi_vec_i),
  .insn_bnd_i   (insn_bnd_i),
  .smm_enter_o  (smm_enter_o),
  .halt_exit_o  (halt_exit_o),
  .load_init_o  (load_init_o),
  .resume_vec_o (resume_vec_o),
  .pend_q       (pend_q),
  .state_q      (state_q)
);

// File: tb/smi_wake_ctl_tb.sv
`timescale 1ns/1ps
module smi_wake_ctl_tb_top;
  localparam int VEC_W = 8;
  localparam int M_PARK = 0, M_BOOT = 1, M_RUN = 2, M_HALT = 3, M_SMM = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smi = 0, init = 0, sipi = 0, bnd = 0, halt = 0, sexit = 0;
  logic [VEC_W-1:0] vec = '0;
  logic [1:0] enter, hexit, load;
  logic [VEC_W-1:0] rvec [2];

  int vectors = 0, fails = 0;
  bit done = 0;

  // reference model, index 0 = non-bootstrap, 1 = bootstrap
  int m_st [2];
  bit m_p [2], m_enter [2], m_hexit [2], m_load [2];
  logic [VEC_W-1:0] m_vec [2];

  always #4 clk = ~clk;

  smi_wake_ctl #(.IS_BSP(1'b0), .VEC_W(VEC_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .smi_req_i(smi), .init_i(init), .sipi_i(sipi),
    .sipi_vec_i(vec), .insn_bnd_i(bnd), .halt_enter_i(halt), .smm_exit_i(sexit),
    .smm_enter_o(enter[0]), .halt_exit_o(hexit[0]), .load_init_o(load[0]),
    .resume_vec_o(rvec[0]));

  smi_wake_ctl #(.IS_BSP(1'b1), .VEC_W(VEC_W)) dut_bsp_i (
    .clk_i(clk), .rst_ni(rst_n), .smi_req_i(smi), .init_i(init), .sipi_i(sipi),
    .sipi_vec_i(vec), .insn_bnd_i(bnd), .halt_enter_i(halt), .smm_exit_i(sexit),
    .smm_enter_o(enter[1]), .halt_exit_o(hexit[1]), .load_init_o(load[1]),
    .resume_vec_o(rvec[1]));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h @%0t", tag, act, exp, $time);
    end
  endtask

  function automatic void model_reset();
    for (int i = 0; i < 2; i++) begin
      m_st[i] = (i == 1) ? M_RUN : M_PARK;
      m_p[i] = 0; m_enter[i] = 0; m_hexit[i] = 0; m_load[i] = 0; m_vec[i] = '0;
    end
  endfunction

  function automatic void model_step();
    for (int i = 0; i < 2; i++) begin
      bit take = 0;
      m_hexit[i] = 0;
      m_load[i] = 0;
      if (init) m_st[i] = (i == 1) ? M_RUN : M_PARK;
      else case (m_st[i])
        M_PARK: if (sipi) begin m_load[i] = 1; m_vec[i] = vec; m_st[i] = M_BOOT; end
        M_BOOT: begin take = m_p[i]; m_st[i] = m_p[i] ? M_SMM : M_RUN; end
        M_RUN: if (bnd && m_p[i]) begin take = 1; m_st[i] = M_SMM; end
               else if (halt) m_st[i] = M_HALT;
        M_HALT: if (m_p[i]) begin take = 1; m_hexit[i] = 1; m_st[i] = M_SMM; end
        default: if (sexit) m_st[i] = M_RUN;
      endcase
      m_p[i] = smi | (m_p[i] & ~take);
      m_enter[i] = take;
    end
  endfunction

  task automatic compare_all();
    for (int i = 0; i < 2; i++) begin
      chk(i ? "R2/R11 enter bsp" : "R2 enter", enter[i], m_enter[i]);
      chk("R3 halt_exit", hexit[i], m_hexit[i]);
      chk("R5 load_init", load[i], m_load[i]);
      chk("R8 resume_vec", rvec[i], m_vec[i]);
    end
  endtask

  // inputs are applied at negedge, one clock, outputs compared at next negedge
  task automatic cyc(bit s_smi = 0, bit s_init = 0, bit s_sipi = 0,
                     logic [VEC_W-1:0] s_vec = '0, bit s_bnd = 0,
                     bit s_halt = 0, bit s_exit = 0);
    smi = s_smi; init = s_init; sipi = s_sipi; vec = s_vec;
    bnd = s_bnd; halt = s_halt; sexit = s_exit;
    @(posedge clk);
    model_step();
    @(negedge clk);
    smi = 0; init = 0; sipi = 0; bnd = 0; halt = 0; sexit = 0;
    compare_all();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240917));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 enter", enter, 2'b00);
    chk("R1 load", load, 2'b00);
    chk("R1 vec", rvec[0], 0);

    // R4, R6: two SMIs while parked, boundaries do nothing
    cyc(.s_smi(1), .s_bnd(1));
    cyc(.s_bnd(1));
    cyc(.s_smi(1), .s_bnd(1));
    cyc(.s_bnd(1));
    chk("R4 parked no entry", enter[0], 0);
    // R5: startup IPI loads, then deferred entry
    cyc(.s_sipi(1), .s_vec(8'h5A));
    chk("R5 load pulse", load[0], 1);
    chk("R5 vector", rvec[0], 8'h5A);
    chk("R5 no entry with load", enter[0], 0);
    cyc();
    chk("R5 deferred entry", enter[0], 1);
    cyc();
    chk("R10 single pulse", enter[0], 0);
    // R6/R10: merged requests gave one entry; nothing left after exit
    cyc(.s_exit(1));
    cyc(.s_bnd(1));
    cyc();
    chk("R6 merged single entry", enter[0], 0);
    // R8: IPI while running ignored
    cyc(.s_sipi(1), .s_vec(8'h33));
    chk("R8 load ignored", load[0], 0);
    chk("R8 vector kept", rvec[0], 8'h5A);
    // R2: needs boundary
    cyc(.s_smi(1));
    cyc();
    cyc();
    chk("R2 no boundary no entry", enter[0], 0);
    cyc(.s_bnd(1));
    chk("R2 entry at boundary", enter[0], 1);
    // R3: halted core woken by SMI
    cyc(.s_exit(1));
    cyc(.s_halt(1));
    cyc(.s_smi(1));
    chk("R3 not yet", hexit[0], 0);
    cyc();
    chk("R3 halt exit", hexit[0], 1);
    chk("R3 entry with halt exit", enter[0], 1);
    // R9: request during SMM latched
    cyc(.s_smi(1));
    cyc();
    chk("R9 no entry inside SMM", enter[0], 0);
    cyc(.s_exit(1));
    cyc(.s_bnd(1));
    chk("R9 entry after exit", enter[0], 1);
    // R7: INIT keeps pending, parks core; R11 bootstrap keeps running
    cyc(.s_exit(1));
    cyc(.s_smi(1));
    cyc(.s_init(1));
    cyc(.s_bnd(1));
    chk("R7 parked after INIT", enter[0], 0);
    chk("R11 bsp entry after INIT", enter[1], 1);
    cyc(.s_bnd(1));
    cyc(.s_sipi(1), .s_vec(8'h11));
    chk("R7 load after INIT", load[0], 1);
    chk("R7 vector after INIT", rvec[0], 8'h11);
    cyc();
    chk("R7 pending survived INIT", enter[0], 1);

    // random phase against the model
    for (int n = 0; n < 4000; n++) begin
      cyc(.s_smi(($urandom % 100) < 10), .s_init(($urandom % 100) < 3),
          .s_sipi(($urandom % 100) < 8), .s_vec(VEC_W'($urandom)),
          .s_bnd(($urandom % 100) < 50), .s_halt(($urandom % 100) < 10),
          .s_exit(($urandom % 100) < 15));
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule